// File: doc/BRIEF.md
# Tag-Renaming Dynamic Scheduler with Broadcast Result Bus

This block takes floating-point style operations in program order and sends them to an adder unit and a multiplier unit. Each unit has a small pool of tagged reservation stations. A four-entry register file keeps a value and a producer tag for each register. When an operation is accepted, every source that has no pending producer gives up its value. A source that does have one gives up the producer's tag instead. The destination register is then renamed to the tag of the chosen station, so later writers and readers of the same register never stall on WAR or WAW conflicts.

A station starts counting its latency once both operands are present. When it finishes, it competes for a single result bus. The bus delivers the value and the tag to every waiting station and to the register file on one clock edge, and the winning station is released on that edge. The arithmetic is an integer stand-in: wrap-around add, subtract and low-half multiply. The latency counters model the pipeline depth. The bus is also driven to the block's outputs through registers, so a testbench or a downstream consumer can watch the completions.

Top module: `dyn_sched_core`

## Requirements
- R1: After synchronous reset, all stations are free, `cdb_valid` is 0, register i holds the value i+1, and no register has a pending producer.
- R2: `in_op` selects the unit: 0 = add, 1 = subtract (adder stations, tags 1 to 3), 2 or 3 = multiply (multiplier stations, tags 4 and 5). `in_ready` is high exactly when a station of the selected kind is free, whatever `in_valid` is. An operation is accepted on an edge where both are high, and it takes the lowest-numbered free station of its kind.
- R3: At acceptance, each source with no pending producer gives its value and each source with a pending producer gives its tag. The destination register's producer becomes the new station's tag.
- R4: Results are 16-bit wrap-around: a+b, a-b, and the low 16 bits of a*b, where a comes from `in_src_a` and b from `in_src_b`.
- R5: When both operands are present at acceptance, the bus result appears at the ports 3 cycles after the accepting edge for add and subtract, and 11 cycles after it for multiply.
- R6: On a broadcast edge, every station waiting on that tag captures the value. Several stations may do so on the same edge. Each starts its latency count on the following cycle.
- R7: If a source's producer broadcasts on the same edge on which the dependent operation is accepted, the value is taken from the bus at acceptance.
- R8: At most one result is broadcast per cycle. A finished multiplier station beats any adder station, and a lower tag beats a higher tag within a unit. A finished station that loses keeps its result until it wins.
- R9: A broadcast updates a register only if that register's producer tag still equals the broadcast tag, and it then clears the tag. A later rename of the register is therefore never overwritten by an older result.
- R10: An operation that writes a register still being read by an earlier waiting operation is accepted without stall, and the earlier operation uses the old value.
- R11: A station is freed on its broadcast edge and can accept a new operation on the next edge.
- R12: A reset applied while operations are in flight discards them: no result is broadcast afterwards, and the register values return to their reset state.

Top module port order follows the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered at the head of the queue |
| in_op | input | 2 | Operation code (0 add, 1 subtract, 2/3 multiply) |
| in_dst | input | 2 | Destination register |
| in_src_a | input | 2 | First source register |
| in_src_b | input | 2 | Second source register |
| in_ready | output | 1 | A station of the required kind is free |
| cdb_valid | output | 1 | A result was broadcast on the last edge |
| cdb_tag | output | 3 | Tag of the broadcasting station |
| cdb_value | output | 16 | Broadcast result value |

## Verification
The assertions check several properties on every cycle. A finished station holds its result until it is granted. A granted station is free on the next cycle. No station finishes while it is still waiting on a tag. The latency counter stays in range. Every pending register tag names a busy station, and every tag on the bus is a legal station number. Only the bench scenarios can show that the values are right: bypass at acceptance, rename-protected register updates under WAW, old operands kept under WAR, and multiple wake-up with the right broadcast order. These scenarios also show the exact completion latency and that in-flight work is discarded by reset.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    FOP_ADD  = 2'd0,
    FOP_SUB  = 2'd1,
    FOP_MUL  = 2'd2,
    FOP_MULX = 2'd3
  } fop_e;

  function automatic logic op_is_mul(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/rs_pool.sv
module rs_pool
  import rsq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int TW     = 3,
  parameter int N      = 3,
  parameter int BASE   = 1,
  parameter int LAT    = 2,
  parameter bit IS_MUL = 1'b0,
  localparam int CW    = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [1:0]    alloc_op,
  input  logic [DW-1:0] alloc_vj,
  input  logic [DW-1:0] alloc_vk,
  input  logic [TW-1:0] alloc_qj,
  input  logic [TW-1:0] alloc_qk,
  output logic          free_any,
  output logic [TW-1:0] free_tag,
  input  logic          cdb_fire,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_val,
  input  logic [N-1:0]  grant,
  output logic [N-1:0]  busy_o,
  output logic [N-1:0]  done_o,
  output logic [N*DW-1:0] res_o
);
  logic [N-1:0]  busy;
  logic [N-1:0]  done;
  logic [1:0]    op  [N];
  logic [DW-1:0] vj  [N];
  logic [DW-1:0] vk  [N];
  logic [TW-1:0] qj  [N];
  logic [TW-1:0] qk  [N];
  logic [CW-1:0] cnt [N];
  int            sel_i;

  // lowest-numbered free station
  always_comb begin
    free_any = 1'b0;
    sel_i    = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_any = 1'b1;
        sel_i    = i;
      end
    end
  end
  assign free_tag = TW'(BASE + sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
      done <= '0;
      for (int i = 0; i < N; i++) begin
        op[i]  <= '0;
        vj[i]  <= '0;
        vk[i]  <= '0;
        qj[i]  <= '0;
        qk[i]  <= '0;
        cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_en && (i == sel_i)) begin
          busy[i] <= 1'b1;
          done[i] <= 1'b0;
          cnt[i]  <= '0;
          op[i]   <= alloc_op;
          vj[i]   <= alloc_vj;
          vk[i]   <= alloc_vk;
          qj[i]   <= alloc_qj;
          qk[i]   <= alloc_qk;
        end else if (grant[i]) begin
          busy[i] <= 1'b0;
          done[i] <= 1'b0;
          cnt[i]  <= '0;
        end else if (busy[i]) begin
          if (cdb_fire && (qj[i] != '0) && (qj[i] == cdb_tag)) begin
            vj[i] <= cdb_val;
            qj[i] <= '0;
          end
          if (cdb_fire && (qk[i] != '0) && (qk[i] == cdb_tag)) begin
            vk[i] <= cdb_val;
            qk[i] <= '0;
          end
          if ((qj[i] == '0) && (qk[i] == '0) && !done[i]) begin
            if (cnt[i] == CW'(LAT - 1)) done[i] <= 1'b1;
            else                        cnt[i]  <= cnt[i] + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy;
  assign done_o = done;

  for (genvar g = 0; g < N; g++) begin : g_st
    logic [DW-1:0] r;
    if (IS_MUL) begin : g_mul
      always_comb r = vj[g] * vk[g];
    end else begin : g_add
      always_comb begin
        if (op[g] == FOP_SUB) r = vj[g] - vk[g];
        else                  r = vj[g] + vk[g];
      end
    end
    assign res_o[g*DW +: DW] = r;

    // R8
    hold_done_chk: assert property (@(posedge clk) disable iff (rst)
      (done[g] && !grant[g]) |=> done[g]);
    // R8
    grant_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
      grant[g] |-> done[g]);
    // R11
    free_after_win_chk: assert property (@(posedge clk) disable iff (rst)
      grant[g] |=> !busy[g]);
    // R6
    ready_before_done_chk: assert property (@(posedge clk) disable iff (rst)
      done[g] |-> (qj[g] == '0 && qk[g] == '0));
    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      busy[g] |-> (cnt[g] <= CW'(LAT - 1)));
  end
endmodule

// File: rtl/cdb_arb.sv
module cdb_arb #(
  parameter int DW    = 16,
  parameter int TW    = 3,
  parameter int NA    = 3,
  parameter int NM    = 2,
  parameter int ABASE = 1,
  parameter int MBASE = 4
) (
  input  logic [NA-1:0]    add_done,
  input  logic [NM-1:0]    mul_done,
  input  logic [NA*DW-1:0] add_res,
  input  logic [NM*DW-1:0] mul_res,
  output logic [NA-1:0]    add_grant,
  output logic [NM-1:0]    mul_grant,
  output logic             fire,
  output logic [TW-1:0]    tag,
  output logic [DW-1:0]    val
);
  always_comb begin
    add_grant = '0;
    mul_grant = '0;
    fire      = 1'b0;
    tag       = '0;
    val       = '0;
    for (int i = 0; i < NM; i++) begin
      if (!fire && mul_done[i]) begin
        fire         = 1'b1;
        mul_grant[i] = 1'b1;
        tag          = TW'(MBASE + i);
        val          = mul_res[i*DW +: DW];
      end
    end
    for (int i = 0; i < NA; i++) begin
      if (!fire && add_done[i]) begin
        fire         = 1'b1;
        add_grant[i] = 1'b1;
        tag          = TW'(ABASE + i);
        val          = add_res[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/reg_status.sv
module reg_status #(
  parameter int NR = 4,
  parameter int DW = 16,
  parameter int TW = 3,
  localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  output logic [DW-1:0] va,
  output logic [TW-1:0] qa,
  output logic [DW-1:0] vb,
  output logic [TW-1:0] qb,
  input  logic          ren_en,
  input  logic [RW-1:0] ren_dst,
  input  logic [TW-1:0] ren_tag,
  input  logic          cdb_fire,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_val,
  output logic [NR*TW-1:0] tags_o
);
  logic [DW-1:0] rval [NR];
  logic [TW-1:0] rtag [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) begin
        rval[i] <= DW'(i + 1);
        rtag[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NR; i++) begin
        if (cdb_fire && (rtag[i] == cdb_tag)) begin
          rval[i] <= cdb_val;
          rtag[i] <= '0;
        end
        if (ren_en && (ren_dst == RW'(i))) rtag[i] <= ren_tag;
      end
    end
  end

  assign va = rval[rd_a];
  assign qa = rtag[rd_a];
  assign vb = rval[rd_b];
  assign qb = rtag[rd_b];

  for (genvar g = 0; g < NR; g++) begin : g_tag
    assign tags_o[g*TW +: TW] = rtag[g];
  end
endmodule

// File: rtl/dyn_sched_core.sv
module dyn_sched_core
  import rsq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int ADD_RS   = 3,
  parameter int MUL_RS   = 2,
  parameter int ADD_LAT  = 2,
  parameter int MUL_LAT  = 10,
  localparam int NUM_RS  = ADD_RS + MUL_RS,
  localparam int TAG_W   = $clog2(NUM_RS + 1),
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src_a,
  input  logic [REG_W-1:0]  in_src_b,
  output logic              in_ready,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_value
);
  localparam int ABASE = 1;
  localparam int MBASE = 1 + ADD_RS;

  logic              want_mul, issue;
  logic              add_free, mul_free;
  logic [TAG_W-1:0]  add_ftag, mul_ftag, dst_tag;
  logic [DATA_W-1:0] va, vb, opa_v, opb_v;
  logic [TAG_W-1:0]  qa, qb, opa_q, opb_q;
  logic              b_fire;
  logic [TAG_W-1:0]  b_tag;
  logic [DATA_W-1:0] b_val;
  logic [ADD_RS-1:0] add_busy, add_done, add_grant;
  logic [MUL_RS-1:0] mul_busy, mul_done, mul_grant;
  logic [ADD_RS*DATA_W-1:0] add_res;
  logic [MUL_RS*DATA_W-1:0] mul_res;
  logic [NUM_REGS*TAG_W-1:0] reg_tags;

  assign want_mul = op_is_mul(in_op);
  assign in_ready = want_mul ? mul_free : add_free;
  assign issue    = in_valid && in_ready;
  assign dst_tag  = want_mul ? mul_ftag : add_ftag;

  // capture a result broadcast on the accepting edge
  always_comb begin
    opa_v = va;
    opa_q = qa;
    opb_v = vb;
    opb_q = qb;
    if (b_fire && (qa != '0) && (qa == b_tag)) begin
      opa_v = b_val;
      opa_q = '0;
    end
    if (b_fire && (qb != '0) && (qb == b_tag)) begin
      opb_v = b_val;
      opb_q = '0;
    end
  end

  reg_status #(.NR(NUM_REGS), .DW(DATA_W), .TW(TAG_W)) u_regs (
    .clk(clk), .rst(rst),
    .rd_a(in_src_a), .rd_b(in_src_b),
    .va(va), .qa(qa), .vb(vb), .qb(qb),
    .ren_en(issue), .ren_dst(in_dst), .ren_tag(dst_tag),
    .cdb_fire(b_fire), .cdb_tag(b_tag), .cdb_val(b_val),
    .tags_o(reg_tags)
  );

  rs_pool #(.DW(DATA_W), .TW(TAG_W), .N(ADD_RS), .BASE(ABASE),
            .LAT(ADD_LAT), .IS_MUL(1'b0)) u_add (
    .clk(clk), .rst(rst),
    .alloc_en(issue && !want_mul), .alloc_op(in_op),
    .alloc_vj(opa_v), .alloc_vk(opb_v), .alloc_qj(opa_q), .alloc_qk(opb_q),
    .free_any(add_free), .free_tag(add_ftag),
    .cdb_fire(b_fire), .cdb_tag(b_tag), .cdb_val(b_val),
    .grant(add_grant), .busy_o(add_busy), .done_o(add_done), .res_o(add_res)
  );

  rs_pool #(.DW(DATA_W), .TW(TAG_W), .N(MUL_RS), .BASE(MBASE),
            .LAT(MUL_LAT), .IS_MUL(1'b1)) u_mul (
    .clk(clk), .rst(rst),
    .alloc_en(issue && want_mul), .alloc_op(in_op),
    .alloc_vj(opa_v), .alloc_vk(opb_v), .alloc_qj(opa_q), .alloc_qk(opb_q),
    .free_any(mul_free), .free_tag(mul_ftag),
    .cdb_fire(b_fire), .cdb_tag(b_tag), .cdb_val(b_val),
    .grant(mul_grant), .busy_o(mul_busy), .done_o(mul_done), .res_o(mul_res)
  );

  cdb_arb #(.DW(DATA_W), .TW(TAG_W), .NA(ADD_RS), .NM(MUL_RS),
            .ABASE(ABASE), .MBASE(MBASE)) u_arb (
    .add_done(add_done), .mul_done(mul_done),
    .add_res(add_res), .mul_res(mul_res),
    .add_grant(add_grant), .mul_grant(mul_grant),
    .fire(b_fire), .tag(b_tag), .val(b_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cdb_valid <= 1'b0;
      cdb_tag   <= '0;
      cdb_value <= '0;
    end else begin
      cdb_valid <= b_fire;
      cdb_tag   <= b_tag;
      cdb_value <= b_val;
    end
  end

  // R8
  bus_tag_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cdb_valid |-> (cdb_tag != '0 && int'(cdb_tag) <= NUM_RS));

  logic [NUM_RS:0] live_by_tag;
  assign live_by_tag = {mul_busy, add_busy, 1'b0};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_live
    logic [TAG_W-1:0] t;
    assign t = reg_tags[g*TAG_W +: TAG_W];
    // R3
    pending_tag_live_chk: assert property (@(posedge clk) disable iff (rst)
      (t != '0) |-> live_by_tag[t]);
  end
endmodule

// File: tb/sim_dyn_sched_core.sv
module sim_dyn_sched_core;
  localparam int CLK_NS = 10;
  localparam int NV = 6;
  // {op, dst, src_a, src_b, tag, value, latency}
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd1, 2'd2, 3'd1, 16'd5,    8'd3},
    {2'd2, 2'd3, 2'd0, 2'd1, 3'd4, 16'd10,   8'd11},
    {2'd1, 2'd1, 2'd3, 2'd0, 3'd1, 16'd5,    8'd3},
    {2'd1, 2'd2, 2'd0, 2'd3, 3'd1, 16'hFFFB, 8'd3},
    {2'd3, 2'd0, 2'd2, 2'd2, 3'd4, 16'd25,   8'd11},
    {2'd0, 2'd3, 2'd0, 2'd1, 3'd1, 16'd30,   8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_op = '0, in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic in_ready, cdb_valid;
  logic [2:0] cdb_tag;
  logic [15:0] cdb_value;
  int checks = 0;
  int errors = 0;

  dyn_sched_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_ready(in_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_value(cdb_value)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, d, a, b);
    int n = 0;
    logic ok;
    in_op = op; in_dst = d; in_src_a = a; in_src_b = b;
    in_valid = 1'b1;
    do begin
      #1 ok = in_ready;
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!ok && n < 50);
    in_valid = 1'b0;
    if (!ok) chk("R2", "accept timeout", 0, 1);
  endtask

  task automatic wait_cdb(string req, int etag, int eval, int ek);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!cdb_valid && k < 60);
    chk(req, "bus valid", int'(cdb_valid), 1);
    chk(req, "bus tag", int'(cdb_tag), etag);
    chk(req, "bus value", int'(cdb_value), eval);
    if (ek >= 0) chk(req, "latency", k, ek);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    in_op = 2'd0; #1 chk("R1", "ready add", int'(in_ready), 1);
    in_op = 2'd2; #1 chk("R1", "ready mul", int'(in_ready), 1);
    chk("R1", "bus idle", int'(cdb_valid), 0);

    // R3 R4 R5 R11: vector walk, one operation at a time
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][34:33], VEC[i][32:31], VEC[i][30:29], VEC[i][28:27]);
      wait_cdb("R3/R4/R5/R11", int'(VEC[i][26:24]), int'(VEC[i][23:8]),
               int'(VEC[i][7:0]));
    end

    // R7 capture from the bus at acceptance
    do_reset();
    issue(2'd0, 2'd0, 2'd1, 2'd2);
    repeat (2) @(negedge clk);
    issue(2'd0, 2'd1, 2'd0, 2'd0);
    chk("R7", "producer on bus", int'(cdb_valid && cdb_tag == 3'd1 && cdb_value == 16'd5), 1);
    wait_cdb("R7", 2, 10, 3);

    // R8 multiplier wins, adder waits one cycle
    do_reset();
    issue(2'd2, 2'd3, 2'd1, 2'd2);
    repeat (7) @(negedge clk);
    issue(2'd0, 2'd0, 2'd1, 2'd1);
    wait_cdb("R8", 4, 6, 3);
    wait_cdb("R8", 1, 4, 1);

    // R9 WAW: stale multiply result must not overwrite register
    do_reset();
    issue(2'd2, 2'd2, 2'd1, 2'd3);
    issue(2'd0, 2'd2, 2'd1, 2'd0);
    wait_cdb("R9", 1, 3, 3);
    wait_cdb("R9", 4, 8, -1);
    issue(2'd0, 2'd3, 2'd2, 2'd2);
    wait_cdb("R9", 1, 6, 3);

    // R10 WAR: waiting reader keeps old operand
    do_reset();
    issue(2'd2, 2'd3, 2'd2, 2'd2);
    issue(2'd0, 2'd0, 2'd3, 2'd1);
    issue(2'd0, 2'd1, 2'd2, 2'd2);
    wait_cdb("R10", 2, 6, 3);
    wait_cdb("R10", 4, 9, 6);
    wait_cdb("R10", 1, 11, 3);
    issue(2'd0, 2'd3, 2'd1, 2'd0);
    wait_cdb("R10", 1, 17, 3);

    // R2 R6 full adder pool, multiple wake-up, R11 release
    do_reset();
    issue(2'd2, 2'd0, 2'd1, 2'd3);
    issue(2'd0, 2'd1, 2'd0, 2'd2);
    issue(2'd0, 2'd2, 2'd0, 2'd0);
    issue(2'd1, 2'd3, 2'd0, 2'd3);
    in_op = 2'd0; #1 chk("R2", "ready add pool full", int'(in_ready), 0);
    in_op = 2'd3; #1 chk("R2", "ready mul free", int'(in_ready), 1);
    wait_cdb("R6", 4, 8, -1);
    wait_cdb("R6", 1, 11, 3);
    wait_cdb("R6", 2, 16, 1);
    wait_cdb("R6", 3, 4, 1);
    in_op = 2'd1; #1 chk("R11", "ready after release", int'(in_ready), 1);

    // R12 reset while in flight
    do_reset();
    issue(2'd2, 2'd0, 2'd1, 2'd1);
    repeat (3) @(negedge clk);
    do_reset();
    begin
      int seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (cdb_valid) seen++;
      end
      chk("R12", "no broadcast after reset", seen, 0);
    end
    issue(2'd0, 2'd3, 2'd0, 2'd0);
    wait_cdb("R12", 1, 2, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule